// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A bus-attached watchdog that counts clock cycles down from a programmed start value. When the count runs out the first time, the block raises a level interrupt and starts the count again from the start value. If software has still not cleared that interrupt when the count runs out again, and the reset stage is enabled, the block raises a system reset request. That request stays up until the block itself is reset.

Software keeps the system alive by writing the interrupt-clear register. That write clears the pending interrupt and restarts the count. A start value of zero with both enables set makes the block fire almost at once, which gives a forced restart.

All registers sit behind a write lock that is opened with a 32-bit key. The bus is a simple APB-style interface with no wait states. Reads are combinational from the address.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the start value and the count both read 0xFFFFFFFF. Control, raw status, masked status and the lock register read 0, so the block comes up unlocked. `irq_o` and `rst_req_o` are low.
- R2: Byte offsets:
  - start value at 0x000
  - live count at 0x004
  - control at 0x008
  - interrupt clear at 0x00C
  - raw status at 0x010
  - masked status at 0x014
  - lock at 0xC00

  A write takes effect at the clock edge of the APB access phase.
- R3: Writing 0x1ACCE551 to the lock register unlocks the block, and the lock register then reads 0. Writing any other value locks it, and it reads 1. While locked, writes to every other offset are ignored.
- R4: Writing the start value reloads the count in the same edge. The count falls by one per cycle while control bit 0 is set, and holds while bit 0 is clear.
- R5: With start value L and counting enabled, the count reaches 0 and on the next edge reloads L and sets the raw interrupt. This happens L+1 cycles after a reload.
- R6: An expiry while the raw interrupt is already set and control bit 1 is set sets a reset flag. With no clear, this is 2(L+1) cycles after the reload. Only `rst_ni` clears the flag.
- R7: Status bit 0 is the interrupt. Raw status shows it regardless of enables. Masked status and `irq_o` are raw AND control bit 0.
- R8: A write to interrupt clear drops the raw interrupt and reloads the count from the start value. Clearing more often than every L+1 cycles therefore keeps `rst_req_o` low.
- R9: Start value 0 followed by control 3 gives `irq_o` one cycle after the control write and `rst_req_o` two cycles after it.
- R10: `rst_req_o` is the reset flag AND control bit 1. Writing control 0 stops counting and drops both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access phase |
| pwrite_i | input | 1 | Write when high |
| paddr_i | input | 12 | Byte offset |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, combinational from `paddr_i` |
| irq_o | output | 1 | First-stage interrupt, level high |
| rst_req_o | output | 1 | Second-stage reset request |

## Verification
Every register write lands at the rising edge that ends the access phase. Reads are combinational, so the bench samples a read one time unit after it sets the address, in the low half of the clock. Taking the write edge as cycle 0, the count reads L−k after k further edges (modulo L+1). The raw interrupt is due at k = L+1 and the reset request at k = 2(L+1). The bench steps exactly k falling edges after each write and compares against functions of L and k. The forced restart is checked at one and two edges after the control write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_START = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_ICLR  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_MSK   = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_LOCK  = 12'hC00;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic rst_en;
    logic run_en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              irq_raw_i,
  output logic [CNT_W-1:0]  start_o,
  output ctrl_t             ctrl_o,
  output logic              reload_o,
  output logic [CNT_W-1:0]  reload_val_o,
  output logic              clr_o
);
  logic [CNT_W-1:0] start_q;
  ctrl_t            ctrl_q;
  logic             locked_q;
  logic             wr_en, wr_ok;

  assign wr_en = psel_i & penable_i & pwrite_i;
  assign wr_ok = wr_en & (~locked_q | (paddr_i == OFF_LOCK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= '1;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else if (wr_ok) begin
      case (paddr_i)
        OFF_START: start_q  <= pwdata_i[CNT_W-1:0];
        OFF_CTRL:  ctrl_q   <= ctrl_t'(pwdata_i[1:0]);
        OFF_LOCK:  locked_q <= (pwdata_i != UNLOCK_KEY);
        default: ;
      endcase
    end
  end

  assign reload_o     = wr_ok & ((paddr_i == OFF_START) | (paddr_i == OFF_ICLR));
  assign reload_val_o = (paddr_i == OFF_START) ? pwdata_i[CNT_W-1:0] : start_q;
  assign clr_o        = wr_ok & (paddr_i == OFF_ICLR);
  assign start_o      = start_q;
  assign ctrl_o       = ctrl_q;

  always_comb begin
    prdata_o = '0;
    case (paddr_i)
      OFF_START: prdata_o = DATA_W'(start_q);
      OFF_COUNT: prdata_o = DATA_W'(cnt_i);
      OFF_CTRL:  prdata_o = DATA_W'(ctrl_q);
      OFF_RAW:   prdata_o = DATA_W'(irq_raw_i);
      OFF_MSK:   prdata_o = DATA_W'(irq_raw_i & ctrl_q.run_en);
      OFF_LOCK:  prdata_o = DATA_W'(locked_q);
      default:   prdata_o = '0;
    endcase
  end

  // locked writes outside the lock register leave state untouched
  assert_locked_ignore_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && wr_en && paddr_i != OFF_LOCK) |=> ($stable(start_q) && $stable(ctrl_q)));

  assert_key_unlocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && paddr_i == OFF_LOCK && pwdata_i == UNLOCK_KEY) |=> !locked_q);
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic             rst_en_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_raw_o,
  output logic             rst_flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q, rst_q;
  logic             expire;

  assign expire = run_en_i & ~reload_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      if (reload_i)      cnt_q <= reload_val_i;
      else if (expire)   cnt_q <= start_i;
      else if (run_en_i) cnt_q <= cnt_q - 1'b1;
      if (expire) begin
        irq_q <= 1'b1;
        if (irq_q && rst_en_i) rst_q <= 1'b1;
      end
      if (clr_i) irq_q <= 1'b0;
    end
  end

  assign cnt_o      = cnt_q;
  assign irq_raw_o  = irq_q;
  assign rst_flag_o = rst_q;

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en_i && !reload_i) |=> $stable(cnt_q));

  assert_expire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en_i && !reload_i && cnt_q == '0) |=> (irq_q && cnt_q == $past(start_i)));

  assert_rst_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> ($past(irq_q) && $past(rst_en_i)));

  assert_rst_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> rst_q);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_q);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] cnt, start, reload_val;
  logic             irq_raw, rst_flag, reload, clr;
  ctrl_t            ctrl;

  wdog_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i, .prdata_o,
    .cnt_i(cnt), .irq_raw_i(irq_raw), .start_o(start), .ctrl_o(ctrl),
    .reload_o(reload), .reload_val_o(reload_val), .clr_o(clr)
  );

  wdog_core #(.CNT_W(CNT_W)) i_core (
    .clk_i, .rst_ni, .run_en_i(ctrl.run_en), .rst_en_i(ctrl.rst_en),
    .reload_i(reload), .reload_val_i(reload_val), .start_i(start), .clr_i(clr),
    .cnt_o(cnt), .irq_raw_o(irq_raw), .rst_flag_o(rst_flag)
  );

  assign irq_o     = irq_raw & ctrl.run_en;
  assign rst_req_o = rst_flag & ctrl.rst_en;

  assert_irq_needs_raw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_raw);
endmodule

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;
  import wdog_pkg::*;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [DATA_W-1:0] pwdata = '0, prdata;
  logic              irq, rst_req;
  int                n_chk = 0, n_fail = 0;
  bit                done = 1'b0;

  always #10 clk = ~clk;

  wdog_two_stage i_wdog_two_stage (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    paddr = a; #1 d = prdata;
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_cnt(input longint l, input longint k);
    return 32'(l - (k % (l + 1)));
  endfunction
  function automatic logic [31:0] exp_raw(input longint l, input longint k);
    return {31'b0, k >= l + 1};
  endfunction
  function automatic logic [31:0] exp_rst(input longint l, input longint k);
    return {31'b0, k >= 2 * (l + 1)};
  endfunction

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    step(3); rst_n = 1'b1; step(1);

    // R1 reset state
    rd(OFF_START, v); check("R1 start", v, 32'hFFFF_FFFF);
    rd(OFF_COUNT, v); check("R1 count", v, 32'hFFFF_FFFF);
    rd(OFF_CTRL, v);  check("R1 ctrl", v, 0);
    rd(OFF_LOCK, v);  check("R1 lock", v, 0);
    rd(OFF_RAW, v);   check("R1 raw", v, 0);
    rd(OFF_MSK, v);   check("R1 masked", v, 0);
    check("R1 irq_o", {31'b0, irq}, 0);
    check("R1 rst_req_o", {31'b0, rst_req}, 0);

    // R3 lock behaviour
    wr(OFF_LOCK, 32'h1);       rd(OFF_LOCK, v);  check("R3 locked reads 1", v, 1);
    wr(OFF_START, 32'h5);      rd(OFF_START, v); check("R3 start ignored", v, 32'hFFFF_FFFF);
    wr(OFF_CTRL, 32'h3);       rd(OFF_CTRL, v);  check("R3 ctrl ignored", v, 0);
    wr(OFF_LOCK, UNLOCK_KEY);  rd(OFF_LOCK, v);  check("R3 key unlocks", v, 0);

    // R4 load reloads, holds while stopped
    wr(OFF_START, 32'd6); rd(OFF_COUNT, v); check("R4 reload on write", v, 6);
    step(3);              rd(OFF_COUNT, v); check("R4 hold when stopped", v, 6);

    // R5 / R6 / R2 full two-stage run, cycle 0 = control write edge
    wr(OFF_CTRL, 32'h3);
    for (int k = 0; k <= 15; k++) begin
      rd(OFF_COUNT, v); check("R5 count", v, exp_cnt(6, k));
      rd(OFF_RAW, v);   check("R5 raw", v, exp_raw(6, k));
      check("R6 rst_req_o timing", {31'b0, rst_req}, exp_rst(6, k));
      step(1);
    end

    // R6 sticky, R8 clear, R10 gating
    wr(OFF_ICLR, 0);
    rd(OFF_RAW, v); check("R8 clear drops raw", v, 0);
    check("R6 flag survives clear", {31'b0, rst_req}, 1);
    wr(OFF_CTRL, 32'h0);
    check("R10 irq_o off", {31'b0, irq}, 0);
    check("R10 rst_req_o off", {31'b0, rst_req}, 0);
    wr(OFF_CTRL, 32'h2);
    check("R6 sticky flag", {31'b0, rst_req}, 1);
    rst_n = 1'b0; step(1); rst_n = 1'b1;
    check("R6 cleared by rst_ni", {31'b0, rst_req}, 0);

    // R7 masking
    wr(OFF_START, 32'd2); wr(OFF_CTRL, 32'h1); step(3);
    rd(OFF_RAW, v); check("R7 raw", v, 1);
    rd(OFF_MSK, v); check("R7 masked", v, 1);
    check("R7 irq_o", {31'b0, irq}, 1);
    wr(OFF_CTRL, 32'h2);
    rd(OFF_RAW, v); check("R7 raw unmasked", v, 1);
    rd(OFF_MSK, v); check("R7 masked off", v, 0);
    check("R7 irq_o off", {31'b0, irq}, 0);
    check("R4 no count no reset", {31'b0, rst_req}, 0);
    wr(OFF_ICLR, 0);
    rd(OFF_COUNT, v); check("R8 clear reloads", v, 2);

    // R8 keepalive avoids reset
    wr(OFF_START, 32'd5); wr(OFF_CTRL, 32'h3);
    for (int i = 0; i < 5; i++) begin
      wr(OFF_ICLR, 0); step(3);
      check("R8 keepalive", {31'b0, rst_req}, 0);
    end

    // R4 / R5 / R8 random trials
    for (int t = 0; t < 24; t++) begin
      int l, k;
      l = 1 + int'($urandom_range(30));
      k = int'($urandom_range(3 * l + 3));
      wr(OFF_CTRL, 32'h1); wr(OFF_START, 32'(l)); wr(OFF_ICLR, 0);
      step(k);
      rd(OFF_COUNT, v); check("R5 random count", v, exp_cnt(l, k));
      rd(OFF_RAW, v);   check("R5 random raw", v, exp_raw(l, k));
      check("R10 no reset without bit1", {31'b0, rst_req}, 0);
    end

    // R9 forced restart
    rst_n = 1'b0; step(1); rst_n = 1'b1;
    wr(OFF_START, 32'd0); wr(OFF_CTRL, 32'h3);
    check("R9 irq at 0", {31'b0, irq}, 0);
    step(1);
    check("R9 irq at 1", {31'b0, irq}, 1);
    check("R9 rst at 1", {31'b0, rst_req}, 0);
    step(1);
    check("R9 rst at 2", {31'b0, rst_req}, 1);

    // R3 clear ignored while locked
    wr(OFF_LOCK, 32'h1); wr(OFF_ICLR, 0);
    rd(OFF_RAW, v); check("R3 clear ignored", v, 1);

    done = 1'b1;
    finish_up();
  end
endmodule